// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block receives configuration words over a write-only three-wire serial link: a serial clock, a serial data line and an active-low load enable. The three pins are brought into a fast system clock domain through synchronizers, and edges are detected there. While the load enable is low, each rising serial clock edge shifts one bit into a 22-bit frame register. A frame holds an 18-bit data field followed by a 4-bit address.

When the load enable rises, the frame is written into the register that its address names. The stored settings drive several controls:
- power enables for the IF section, the RF section and the reference amplifier;
- the choice of which of the two RF loops feeds the shared RF output;
- an auxiliary pin that is either held low or shows an active-low lock warning.

The three divider values are also brought out for the loops that sit outside this block.

Top module: `tw_cfg_port`

## Requirements
- R1: While `ser_load_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into the frame. The first bit is data bit 17 and the order runs down to data bit 0, followed by address bit 3 down to address bit 0.
- R2: A frame is written only on the rising edge of `ser_load_n`, and only into the register its address selects. Until that edge, no output changes.
- R3: Any number of extra bits may be shifted in ahead of a frame; only the last 22 bits shifted before the load edge count.
- R4: Frames addressed to 1 or to 6 through 15 are discarded and change no output.
- R5: After reset, every stored value is zero. All power enables are off, all divider outputs are 0, `rf_sel2` is 0 and `aux_out` is low.
- R6: While `hw_power` is low, `if_on`, `rf_on` and `ref_on` are all low, whatever is stored.
- R7: With `hw_power` high, a 1 in bit 3 of the register at address 0 turns on both `if_on` and `rf_on`.
- R8: With `hw_power` high and address 0 bit 3 clear, bit 1 of the register at address 2 drives `if_on` and bit 0 drives `rf_on`.
- R9: `ref_on` is high exactly when `if_on` or `rf_on` is high.
- R10: Writing address 3 sets `rf_sel2` to 0 and loads `n_rf1` from data bits 17:0. Writing address 4 sets `rf_sel2` to 1. The selection holds through writes to other addresses.
- R11: When bits 13:12 of the register at address 0 equal 11, `aux_out` equals `if_busy` OR `rf_busy`. For every other value, `aux_out` is low.
- R12: Frames are accepted and stored while `hw_power` is low and while both sections are disabled.
- R13: Address 4 loads `n_rf2` from data bits 16:0, and address 5 loads `n_if` from data bits 15:0. Higher data bits are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, sampled in the system clock domain |
| ser_dat | input | 1 | Serial data |
| ser_load_n | input | 1 | Active-low load enable; its rising edge writes the frame |
| hw_power | input | 1 | Hardware power pin; low forces every section off |
| if_busy | input | 1 | IF loop not-ready flag |
| rf_busy | input | 1 | RF loop not-ready flag |
| if_on | output | 1 | IF section power enable |
| rf_on | output | 1 | RF section power enable |
| ref_on | output | 1 | Reference amplifier power enable |
| rf_sel2 | output | 1 | 0 selects RF loop 1 for the shared output, 1 selects loop 2 |
| aux_out | output | 1 | Auxiliary output |
| n_rf1 | output | 18 | RF loop 1 divider value |
| n_rf2 | output | 17 | RF loop 2 divider value |
| n_if | output | 16 | IF loop divider value |

## Verification
The assertions assume that each level on `ser_clk`, `ser_load_n` and `ser_dat` lasts several system clock cycles. They also assume that data is stable around every serial clock rise, and that `ser_clk` is not rising when the load enable moves. Without this, the synchronizers could merge or skip edges. The bench holds every serial level for four system cycles and changes data only while the serial clock is low. It raises the load enable only after the last clock has returned low.

// File: rtl/tw_cfg_port.sv
module tw_cfg_port #(
  parameter int DW  = 18,
  parameter int AW  = 4,
  parameter int N1W = 18,
  parameter int N2W = 17,
  parameter int NIW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_load_n,
  input  logic           hw_power,
  input  logic           if_busy,
  input  logic           rf_busy,
  output logic           if_on,
  output logic           rf_on,
  output logic           ref_on,
  output logic           rf_sel2,
  output logic           aux_out,
  output logic [N1W-1:0] n_rf1,
  output logic [N2W-1:0] n_rf2,
  output logic [NIW-1:0] n_if
);
  localparam int FW = DW + AW;
  localparam logic [AW-1:0] A_MAIN = AW'(0);
  localparam logic [AW-1:0] A_PWR  = AW'(2);
  localparam logic [AW-1:0] A_N1   = AW'(3);
  localparam logic [AW-1:0] A_N2   = AW'(4);
  localparam logic [AW-1:0] A_NIF  = AW'(5);
  localparam int B_AUX   = 12;
  localparam int B_FORCE = 3;

  logic [2:0]    ck_q, ld_q;
  logic [1:0]    dt_q;
  logic [FW-1:0] sh;
  logic [1:0]    aux_mode;
  logic          force_on, if_bit, rf_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      ld_q <= '1;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      ld_q <= {ld_q[1:0], ser_load_n};
      dt_q <= {dt_q[0], ser_dat};
    end

  wire ck_rise = ck_q[1] & ~ck_q[2];
  wire ld_low  = ~ld_q[1];
  wire commit  = ld_q[1] & ~ld_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 sh <= '0;
    else if (ck_rise && ld_low) sh <= {sh[FW-2:0], dt_q[1]};

  wire [AW-1:0] addr = sh[AW-1:0];
  wire [DW-1:0] dat  = sh[FW-1:AW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      aux_mode <= '0;
      force_on <= 1'b0;
      if_bit   <= 1'b0;
      rf_bit   <= 1'b0;
      n_rf1    <= '0;
      n_rf2    <= '0;
      n_if     <= '0;
      rf_sel2  <= 1'b0;
    end else if (commit) begin
      case (addr)
        A_MAIN: begin
          aux_mode <= dat[B_AUX+1:B_AUX];
          force_on <= dat[B_FORCE];
        end
        A_PWR: begin
          if_bit <= dat[1];
          rf_bit <= dat[0];
        end
        A_N1: begin
          n_rf1   <= dat[N1W-1:0];
          rf_sel2 <= 1'b0;
        end
        A_N2: begin
          n_rf2   <= dat[N2W-1:0];
          rf_sel2 <= 1'b1;
        end
        A_NIF:   n_if <= dat[NIW-1:0];
        default: ;
      endcase
    end

  assign if_on   = hw_power & (force_on | if_bit);
  assign rf_on   = hw_power & (force_on | rf_bit);
  assign ref_on  = if_on | rf_on;
  assign aux_out = (aux_mode == 2'b11) & (if_busy | rf_busy);

  wire [N1W+N2W+NIW+5:0] state = {n_rf1, n_rf2, n_if, rf_sel2, aux_mode, force_on, if_bit, rf_bit};

  AST_SHIFT_ONLY_WHEN_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    !(ck_rise && ld_low) |=> $stable(sh)); // R1
  AST_HOLD_UNTIL_LOAD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(state)); // R2
  AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (addr == AW'(1) || addr > A_NIF) |=> $stable(state)); // R4
  AST_PIN_LOW_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_power |-> !if_on && !rf_on && !ref_on); // R6
  AST_SEL_LOOP1: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr == A_N1 |=> !rf_sel2); // R10
  AST_SEL_LOOP2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr == A_N2 |=> rf_sel2); // R10
  AST_AUX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    aux_mode != 2'b11 |-> !aux_out); // R11
endmodule

// File: tb/test_tw_cfg_port.sv
module test_tw_cfg_port;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_dat = 0, ser_load_n = 1, hw_power = 0, if_busy = 0, rf_busy = 0;
  logic if_on, rf_on, ref_on, rf_sel2, aux_out;
  logic [17:0] n_rf1;
  logic [16:0] n_rf2;
  logic [15:0] n_if;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tw_cfg_port i_tw_cfg_port (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin();
    @(negedge clk); ser_load_n = 0; wait_cyc(4);
  endtask

  task automatic put_bit(logic b);
    ser_dat = b; wait_cyc(4);
    ser_clk = 1; wait_cyc(4);
    ser_clk = 0;
  endtask

  task automatic frame_end();
    wait_cyc(4); ser_load_n = 1; wait_cyc(8);
  endtask

  task automatic send(logic [17:0] d, logic [3:0] a, int extra = 0);
    logic [21:0] w = {d, a};
    frame_begin();
    for (int i = 0; i < extra; i++) put_bit(i[0] ^ i[2]);
    for (int i = 21; i >= 0; i--) put_bit(w[i]);
    frame_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3); rst_n = 1; wait_cyc(2);
    // R5 reset state
    chk("R5 n_rf1", n_rf1, 0); chk("R5 n_rf2", n_rf2, 0); chk("R5 n_if", n_if, 0);
    chk("R5 power", {if_on, rf_on, ref_on}, 0); chk("R5 sel", rf_sel2, 0);
    chk("R5 aux", aux_out, 0);

    // R12 writes stored while powered down; R1 bit order
    send(18'h2A5C3, 4'd3);
    chk("R1 R12 n_rf1 order", n_rf1, 18'h2A5C3); chk("R10 sel loop1", rf_sel2, 0);
    // R13 field widths
    send(18'h3FFFF, 4'd4);
    chk("R13 n_rf2 width", n_rf2, 17'h1FFFF); chk("R10 sel loop2", rf_sel2, 1);
    send(18'h31C2F, 4'd5);
    chk("R13 n_if width", n_if, 16'h1C2F); chk("R10 sel persists", rf_sel2, 1);

    // R3 leading extra bits ignored
    for (int k = 1; k <= 9; k += 4) begin
      send(18'(7150 + k), 4'd5, k);
      chk("R3 extra bits", n_if, 32'(7150 + k));
    end

    // R2 no update before load edge
    frame_begin();
    for (int i = 21; i >= 0; i--) put_bit(((22'(7215) << 4) | 22'd5) >> i);
    wait_cyc(10);
    chk("R2 held before edge", n_if, 32'(7159));
    frame_end();
    chk("R2 written at edge", n_if, 7215);

    // R4 reserved addresses dropped
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a > 5) begin
        send(18'h3FFFF, 4'(a));
        chk("R4 n_rf1", n_rf1, 18'h2A5C3); chk("R4 n_rf2", n_rf2, 17'h1FFFF);
        chk("R4 n_if", n_if, 7215); chk("R4 sel", rf_sel2, 1);
        hw_power = 1; wait_cyc(1);
        chk("R4 power", {if_on, rf_on}, 0); chk("R4 aux", aux_out, 0);
        hw_power = 0;
      end
    end

    send(18'h00001, 4'd3);
    chk("R10 back to loop1", rf_sel2, 0);
    send(18'h00002, 4'd5);
    chk("R10 holds loop1", rf_sel2, 0);

    // R6 R7 R8 R9 exhaustive power sweep
    for (int c = 0; c < 8; c++) begin
      send(18'(c[2] << 3), 4'd0);
      send(18'(c[1:0]), 4'd2);
      for (int p = 0; p < 2; p++) begin
        logic ei, er;
        hw_power = p[0]; wait_cyc(2);
        ei = p[0] & (c[2] | c[1]);
        er = p[0] & (c[2] | c[0]);
        chk(p ? "R7 R8 if_on" : "R6 if_on", if_on, ei);
        chk(p ? "R7 R8 rf_on" : "R6 rf_on", rf_on, er);
        chk("R9 ref_on", ref_on, ei | er);
      end
      hw_power = 0;
    end

    // R11 aux sweep
    for (int m = 0; m < 4; m++) begin
      send(18'(m << 12), 4'd0);
      for (int b = 0; b < 4; b++) begin
        if_busy = b[1]; rf_busy = b[0]; wait_cyc(2);
        chk("R11 aux", aux_out, (m == 3) & (b != 0));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule